// File: doc/BRIEF.md
# CAN Error-State Status Encoder

This block turns the two fault-confinement counters of a CAN controller into compact bus-state codes. It takes the transmit and receive error counts and maps each to a 2-bit severity level: normal, warning, error-passive or bus-off. It keeps the last reported pair of codes and raises a status-change flag when the state computed from the counters no longer matches the reported pair.

The status interrupt is blocking. While the change flag is pending, the reported codes stay frozen, so software always reads the pair that caused the interrupt. Further threshold crossings are held back until software acknowledges the flag with a clear pulse. On the cycle after the clear, any remaining difference loads at once and sets the flag again. Bus-off is the most severe transmitter condition, so it is copied into the receiver code as well. When the transmitter recovers, the receiver code first drops to normal.

Top module: `can_err_status`

## Requirements
- R1: With the transmitter not in bus-off, the receiver state computed from the receive count is 00 for 0..96, 01 for 97..127 and 10 for 128 and above.
- R2: The transmitter state computed from the transmit count is 00 for 0..96, 01 for 97..127, 10 for 128..255 and 11 (bus-off) for 256 and above.
- R3: Whenever the computed transmitter state is 11, the computed receiver state is 11, whatever the receive count. A reported transmitter code of 11 always comes with a reported receiver code of 11.
- R4: When the reported transmitter code is 11 and the computed transmitter state is not 11, the computed receiver state is 00, whatever the receive count.
- R5: When the flag is low and the computed pair differs from the reported pair, the next clock edge loads the computed pair into the reported codes and sets the flag. When the pair does not differ, nothing changes.
- R6: While the flag is high, the reported codes keep their values at every edge, whatever the counters do.
- R7: A clear strobe while the flag is high drops the flag at the next edge and leaves the codes unchanged. The flag falls only through a clear, and a clear while the flag is low has no effect.
- R8: The interrupt request is high exactly when the flag is high and the interrupt enable is high.
- R9: A synchronous reset sets both codes to 00 and clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_err_cnt | input | 9 | Transmit error count |
| rx_err_cnt | input | 8 | Receive error count |
| flag_clr | input | 1 | Clear strobe for the change flag |
| irq_en | input | 1 | Interrupt enable (mask when low) |
| rx_state | output | 2 | Reported receiver state code |
| tx_state | output | 2 | Reported transmitter state code |
| chg_flag | output | 1 | Status-change flag |
| irq_req | output | 1 | Masked interrupt request |

## Verification
The properties assume that reset is high on the first clock edge. They assume the counters, the clear strobe and the enable are stable around each rising edge. They do not assume the counters move by small steps, and they do not assume the clear lasts exactly one cycle. The stimulus therefore lets counts jump anywhere in range, while weighting them toward the values just either side of 96, 127 and 255. It drives clear strobes that land both while the flag is high and while it is low, including strobes that last more than one cycle. It also toggles the enable on its own, so the mask is exercised separately from the flag.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_WARN    = 2'b01,
        ST_PASSIVE = 2'b10,
        ST_BUSOFF  = 2'b11
    } bus_st_t;

    typedef struct packed {
        bus_st_t rx;
        bus_st_t tx;
    } st_pair_t;

    localparam st_pair_t PAIR_IDLE = '{rx: ST_OK, tx: ST_OK};

    // Transmitter severity from its count and the three limits.
    function automatic bus_st_t tx_level(input int unsigned cnt,
                                         input int unsigned warn_lim,
                                         input int unsigned pass_lim,
                                         input int unsigned off_lim);
        if (cnt > off_lim)       return ST_BUSOFF;
        else if (cnt > pass_lim) return ST_PASSIVE;
        else if (cnt > warn_lim) return ST_WARN;
        else                     return ST_OK;
    endfunction

    // Receiver severity; the receiver never reaches bus-off from its own count.
    function automatic bus_st_t rx_level(input int unsigned cnt,
                                         input int unsigned warn_lim,
                                         input int unsigned pass_lim);
        if (cnt > pass_lim)      return ST_PASSIVE;
        else if (cnt > warn_lim) return ST_WARN;
        else                     return ST_OK;
    endfunction

endpackage

// File: rtl/can_err_classify.sv
module can_err_classify
    import can_err_pkg::*;
#(
    parameter int TX_CNT_W  = 9,
    parameter int RX_CNT_W  = 8,
    parameter int WARN_LIM  = 96,
    parameter int PASS_LIM  = 127,
    parameter int OFF_LIM   = 255
) (
    input  logic [TX_CNT_W-1:0] tx_cnt,
    input  logic [RX_CNT_W-1:0] rx_cnt,
    input  bus_st_t             shown_tx,
    output st_pair_t            target
);

    bus_st_t tx_raw;
    bus_st_t rx_raw;

    always_comb begin
        tx_raw = tx_level(32'(tx_cnt), WARN_LIM, PASS_LIM, OFF_LIM);
        rx_raw = rx_level(32'(rx_cnt), WARN_LIM, PASS_LIM);
    end

    // Bus-off dominates the receiver code; leaving bus-off passes through OK.
    always_comb begin
        target.tx = tx_raw;
        if (tx_raw == ST_BUSOFF)
            target.rx = ST_BUSOFF;
        else if (shown_tx == ST_BUSOFF)
            target.rx = ST_OK;
        else
            target.rx = rx_raw;
    end

endmodule

// File: rtl/can_err_hold.sv
module can_err_hold
    import can_err_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  st_pair_t target,
    input  logic     clr,
    output st_pair_t shown,
    output logic     pending
);

    logic differs;

    always_comb differs = (target != shown);

    always_ff @(posedge clk) begin
        if (rst) begin
            shown   <= PAIR_IDLE;
            pending <= 1'b0;
        end else if (pending) begin
            if (clr)
                pending <= 1'b0;
        end else if (differs) begin
            shown   <= target;
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/can_err_status.sv
module can_err_status
    import can_err_pkg::*;
#(
    parameter int TX_CNT_W = 9,
    parameter int RX_CNT_W = 8,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 127,
    parameter int OFF_LIM  = 255
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TX_CNT_W-1:0] tx_err_cnt,
    input  logic [RX_CNT_W-1:0] rx_err_cnt,
    input  logic                flag_clr,
    input  logic                irq_en,
    output logic [1:0]          rx_state,
    output logic [1:0]          tx_state,
    output logic                chg_flag,
    output logic                irq_req
);

    st_pair_t target;
    st_pair_t shown;
    logic     pending;

    can_err_classify #(
        .TX_CNT_W (TX_CNT_W),
        .RX_CNT_W (RX_CNT_W),
        .WARN_LIM (WARN_LIM),
        .PASS_LIM (PASS_LIM),
        .OFF_LIM  (OFF_LIM)
    ) u_classify (
        .tx_cnt   (tx_err_cnt),
        .rx_cnt   (rx_err_cnt),
        .shown_tx (shown.tx),
        .target   (target)
    );

    can_err_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .target  (target),
        .clr     (flag_clr),
        .shown   (shown),
        .pending (pending)
    );

    assign rx_state = shown.rx;
    assign tx_state = shown.tx;
    assign chg_flag = pending;
    assign irq_req  = pending & irq_en;

endmodule

// File: rtl/can_err_status_chk.sv
module can_err_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       flag_clr,
    input logic       irq_en,
    input logic [1:0] rx_state,
    input logic [1:0] tx_state,
    input logic       chg_flag,
    input logic       irq_req
);

    assert_rst_idle_R9: assert property (@(posedge clk)
        rst |=> (rx_state == 2'b00 && tx_state == 2'b00 && !chg_flag));

    assert_busoff_mirror_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_state == 2'b11) |-> (rx_state == 2'b11));

    assert_rise_loads_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_flag) |-> (rx_state != $past(rx_state) || tx_state != $past(tx_state)));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        chg_flag |=> ($stable(rx_state) && $stable(tx_state)));

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (chg_flag && flag_clr) |=> !chg_flag);

    assert_fall_needs_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(chg_flag) |-> $past(flag_clr));

    assert_masked_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq_req);

    assert_req_has_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> chg_flag);

endmodule

bind can_err_status can_err_status_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .rx_state (rx_state),
    .tx_state (tx_state),
    .chg_flag (chg_flag),
    .irq_req  (irq_req)
);

// File: tb/sim_can_err_status.sv
module sim_can_err_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] tx_err_cnt = '0;
    logic [7:0] rx_err_cnt = '0;
    logic       flag_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic [1:0] rx_state;
    logic [1:0] tx_state;
    logic       chg_flag;
    logic       irq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [1:0] e_rx = 2'b00;
    logic [1:0] e_tx = 2'b00;
    logic       e_flag = 1'b0;

    always #4 clk = ~clk;

    can_err_status u0 (
        .clk        (clk),
        .rst        (rst),
        .tx_err_cnt (tx_err_cnt),
        .rx_err_cnt (rx_err_cnt),
        .flag_clr   (flag_clr),
        .irq_en     (irq_en),
        .rx_state   (rx_state),
        .tx_state   (tx_state),
        .chg_flag   (chg_flag),
        .irq_req    (irq_req)
    );

    function automatic logic [1:0] m_tx(input int c);
        if (c > 255) return 2'b11;
        if (c > 127) return 2'b10;
        if (c > 96)  return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [1:0] m_rx(input int c);
        if (c > 127) return 2'b10;
        if (c > 96)  return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step(input string tag);
        logic [1:0] ntx;
        logic [1:0] nrx;
        @(posedge clk);
        if (rst) begin
            e_rx = 2'b00; e_tx = 2'b00; e_flag = 1'b0;
        end else begin
            ntx = m_tx(int'(tx_err_cnt));
            nrx = (ntx == 2'b11) ? 2'b11 : ((e_tx == 2'b11) ? 2'b00 : m_rx(int'(rx_err_cnt)));
            if (e_flag) begin
                if (flag_clr) e_flag = 1'b0;
            end else if (ntx != e_tx || nrx != e_rx) begin
                e_tx = ntx; e_rx = nrx; e_flag = 1'b1;
            end
        end
        @(negedge clk);
        chk(tag, "rx_state", int'(rx_state), int'(e_rx));
        chk(tag, "tx_state", int'(tx_state), int'(e_tx));
        chk(tag, "chg_flag", int'(chg_flag), int'(e_flag));
        chk(tag, "irq_req",  int'(irq_req),  int'(e_flag & irq_en));
    endtask

    task automatic apply(input int t, input int r, input string tag);
        tx_err_cnt = t[8:0];
        rx_err_cnt = r[7:0];
        flag_clr = 1'b0;
        step(tag);
    endtask

    task automatic ack(input string tag);
        flag_clr = 1'b1;
        step(tag);
        flag_clr = 1'b0;
    endtask

    function automatic int pick_edge(input int maxv);
        int v;
        case ($urandom_range(0, 7))
            0: v = 96;  1: v = 97;  2: v = 127; 3: v = 128;
            4: v = 255; 5: v = 256; 6: v = 0;
            default: v = int'($urandom_range(0, maxv));
        endcase
        if (v > maxv) v = maxv;
        return v;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        rst = 1'b1;
        step("R9");
        step("R9");
        rst = 1'b0;
        irq_en = 1'b1;

        // R1 receiver thresholds
        apply(0, 96, "R1_at96");
        apply(0, 97, "R1_at97");
        ack("R7_clear");
        apply(0, 127, "R1_at127");
        apply(0, 128, "R1_at128");
        // R6 frozen while pending, R7 clear then reload
        apply(0, 0, "R6_hold");
        apply(300, 0, "R6_hold");
        apply(0, 0, "R6_hold");
        ack("R7_clear");
        apply(0, 0, "R5_reload");
        ack("R7_clear");
        flag_clr = 1'b1;
        step("R7_noeffect");
        flag_clr = 1'b0;
        // R2 transmitter thresholds
        apply(96, 0, "R2_at96");
        apply(97, 0, "R2_at97");   ack("R7_clear");
        apply(127, 0, "R2_at127");
        apply(128, 0, "R2_at128"); ack("R7_clear");
        apply(255, 0, "R2_at255");
        apply(256, 0, "R2_at256_R3"); ack("R7_clear");
        apply(511, 200, "R3_mirror");
        // R4 leaving bus-off with high receive count
        apply(0, 120, "R4_exit");  ack("R7_clear");
        apply(0, 120, "R4_then_rx");
        // R8 mask
        irq_en = 1'b0;
        apply(0, 120, "R8_masked");
        irq_en = 1'b1;
        apply(0, 120, "R8_unmasked");
        ack("R7_clear");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            tx_err_cnt = 9'(pick_edge(511));
            rx_err_cnt = 8'(pick_edge(255));
            flag_clr = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) irq_en = ~irq_en;
            step("R5_rand");
        end
        flag_clr = 1'b0;

        rst = 1'b1;
        step("R9_late");
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule